// File: doc/BRIEF.md
# Hall Change Tachometer Pulser

This block watches the three Hall-effect position sensors of a brushless motor. Each sensor line first passes through a two-flop synchronizer. Whenever the synchronized 3-bit code differs from the code held in the position register, the new code is captured. In the same cycle, a tachometer pulse of fixed, programmable width is started. Because every pulse has the same width, the long-run average of the tach output rises in proportion to rotor speed. An external averaging filter can turn that output into a speed feedback signal.

The pulse width is given in clock cycles on `width_i`. The width counter is sized by a parameter. Its default of 21 bits covers widths from a few microseconds up to beyond 10 ms at a 200 MHz clock. A brake input silences the tach output. It stops any pulse in progress and blocks new ones, while the position register keeps tracking the sensors. Every pin is a plain level-sampled control or status signal. The block has no streaming data path, so it needs no valid/ready handshake and applies no back-pressure.

After reset, the position register settles silently onto the synchronized sensor code without producing a pulse.

Top module: `hall_tach_pulser`

## Requirements
- R1: While `rst_n` is low, `pos_o` reads 0 and `tach_o` reads 0.
- R2: After reset is released with steady sensors, `pos_o` equals `hall_i` at the third rising edge. No tach pulse is produced by this settling.
- R3: A change on `hall_i` reaches `pos_o` at the third rising edge after it is applied. Two of these edges are the synchronizer and one is the position register. Before that edge, `pos_o` keeps the old code.
- R4: When brake is low and the width is nonzero, `tach_o` goes high at the same edge that loads the new code into `pos_o`.
- R5: A pulse stays high for exactly the value on `width_i` at the loading edge, counted in clock cycles. Widths 1 and 2^WIDTH_BITS-1 are both valid.
- R6: A width of 0 produces no pulse, but the position is still captured.
- R7: A code change that lands while a pulse is active reloads the width counter. The pulse then ends `width_i` cycles after the later loading edge, with no low gap between the two pulses.
- R8: With `brake_i` high, `tach_o` is low from the edge after brake is sampled. While brake stays high, code changes still update `pos_o` but start no pulse. Releasing brake starts no pulse.
- R9: While the synchronized code equals the held code, `pos_o` is stable and no pulse starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Raw Hall sensor levels, asynchronous to clk |
| brake_i | input | 1 | High silences the tach output |
| width_i | input | WIDTH_BITS | Tach pulse width in clock cycles |
| pos_o | output | 3 | Latched rotor position code |
| tach_o | output | 1 | Fixed-width tach pulse |

## Verification
The main path is driven with single-bit sensor steps around the six-state commutation cycle. It is also driven with a multi-bit jump. The step tests show that each stage of the synchronize-then-capture delay is counted correctly. The jump shows that the whole code is compared, not one line alone.

Pulse widths of 0, 1, 5 and the all-ones maximum separate a miscounted pulse from an off-by-one end or a missing guard on zero. A second change during a live pulse distinguishes reloading from ignoring the change or adding a fresh pulse after the old one. Brake is applied in the middle of a pulse, then held across a sensor change, then released. This shows that brake silences only the tach output, not position tracking.

// File: rtl/hall_tach_pkg.sv
`timescale 1ns/1ps
package hall_tach_pkg;
  localparam int HALL_BITS = 3;
  typedef logic [HALL_BITS-1:0] hall_code_t;
endpackage

// File: rtl/hall_sync.sv
`timescale 1ns/1ps
module hall_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hall_pos_latch.sv
`timescale 1ns/1ps
module hall_pos_latch #(
  parameter int W      = 3,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] pos_o,
  output logic         fire_o
);
  localparam int SC_W = $clog2(SETTLE + 1);

  logic [SC_W-1:0] settle_q;
  logic            armed;
  logic [W-1:0]    pos_q;

  assign armed  = (settle_q == SC_W'(SETTLE));
  assign fire_o = armed && (sync_i != pos_q);
  assign pos_o  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      settle_q <= '0;
    else if (!armed) settle_q <= settle_q + SC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos_q <= '0;
    else if (!armed || fire_o) pos_q <= sync_i;
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> pos_q == $past(sync_i));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sync_i == pos_q) |=> $stable(pos_q));
endmodule

// File: rtl/tach_pulse_timer.sv
`timescale 1ns/1ps
module tach_pulse_timer #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger_i,
  input  logic             brake_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             tach_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rem_q <= '0;
    else if (brake_i)         rem_q <= '0;
    else if (trigger_i)       rem_q <= width_i;
    else if (rem_q != '0)     rem_q <= rem_q - CNT_W'(1);
  end

  assign tach_o = (rem_q != '0);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_i && !brake_i && width_i != '0) |=> tach_o);

  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger_i && !brake_i && width_i == '0) |=> !tach_o);

  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_o && !trigger_i && !brake_i) |=> rem_q == $past(rem_q) - CNT_W'(1));

  p_brake_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brake_i |=> !tach_o);
endmodule

// File: rtl/hall_tach_pulser.sv
`timescale 1ns/1ps
module hall_tach_pulser #(
  parameter int WIDTH_BITS  = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            hall_i,
  input  logic                  brake_i,
  input  logic [WIDTH_BITS-1:0] width_i,
  output logic [2:0]            pos_o,
  output logic                  tach_o
);
  import hall_tach_pkg::*;

  localparam int SETTLE = SYNC_STAGES + 1;

  hall_code_t hall_sync_w;
  logic       fire_w;

  hall_sync #(.W(HALL_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hall_i),
    .q_o   (hall_sync_w)
  );

  hall_pos_latch #(.W(HALL_BITS), .SETTLE(SETTLE)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (hall_sync_w),
    .pos_o  (pos_o),
    .fire_o (fire_w)
  );

  tach_pulse_timer #(.CNT_W(WIDTH_BITS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger_i (fire_w),
    .brake_i   (brake_i),
    .width_i   (width_i),
    .tach_o    (tach_o)
  );

  p_pulse_with_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tach_o) && !$past(brake_i)) |-> (pos_o != $past(pos_o)));
endmodule

// File: tb/hall_tach_pulser_tb.sv
`timescale 1ns/1ps
module hall_tach_pulser_tb;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    hall = 3'b101;
  logic          brake = 1'b0;
  logic [TW-1:0] width = TW'(5);
  logic [2:0]    pos;
  logic          tach;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hall_tach_pulser #(.WIDTH_BITS(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .brake_i(brake),
    .width_i(width), .pos_o(pos), .tach_o(tach)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic high_len(output int n);
    n = 0;
    while (tach === 1'b1 && n < 2000) begin
      n++;
      step(1);
    end
  endtask

  // drive a new code at a negedge, check the capture timing and the pulse
  task automatic move(logic [2:0] nv, string req, int exp_len);
    logic [2:0] ov;
    int n;
    ov = pos;
    hall = nv;
    step(2);
    chk(req, "pos before capture", pos, ov);
    chk(req, "tach before capture", tach, 0);
    step(1);
    chk(req, "pos at capture", pos, nv);
    chk(req, "tach at capture", tach, exp_len > 0 ? 1 : 0);
    high_len(n);
    chk(req, "pulse length", n, exp_len);
  endtask

  task automatic t_reset;
    chk("R1", "pos in reset", pos, 0);
    chk("R1", "tach in reset", tach, 0);
    rst_n = 1'b1;
    step(3);
    chk("R2", "pos after settle", pos, 3'b101);
    for (int i = 0; i < 10; i++) begin
      if (tach !== 1'b0) chk("R2", "tach during settle", tach, 0);
      step(1);
    end
    chk("R2", "tach after settle", tach, 0);
  endtask

  task automatic t_commutation;
    logic [2:0] seq [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    width = TW'(5);
    for (int i = 0; i < 6; i++) begin
      move(seq[i], "R3", 5);
      step(2);
    end
    move(3'b010, "R4", 5);
    step(2);
  endtask

  task automatic t_widths;
    width = TW'(1);
    move(3'b110, "R5", 1);
    step(2);
    width = {TW{1'b1}};
    move(3'b100, "R5", (1 << TW) - 1);
    step(2);
    width = '0;
    move(3'b101, "R6", 0);
    for (int i = 0; i < 8; i++) begin
      if (tach !== 1'b0) chk("R6", "tach with zero width", tach, 0);
      step(1);
    end
    chk("R6", "pos with zero width", pos, 3'b101);
  endtask

  task automatic t_retrigger;
    int n;
    width = TW'(5);
    hall = 3'b001;
    step(3);
    chk("R7", "first pulse up", tach, 1);
    step(1);
    hall = 3'b011;
    high_len(n);
    chk("R7", "merged pulse length", n, 5 + 3);
    chk("R7", "pos after reload", pos, 3'b011);
    step(2);
  endtask

  task automatic t_brake;
    width = TW'(20);
    hall = 3'b010;
    step(3);
    chk("R8", "pulse up before brake", tach, 1);
    step(2);
    brake = 1'b1;
    step(1);
    chk("R8", "tach cut by brake", tach, 0);
    hall = 3'b110;
    step(3);
    chk("R8", "pos under brake", pos, 3'b110);
    chk("R8", "no pulse under brake", tach, 0);
    for (int i = 0; i < 25; i++) begin
      if (tach !== 1'b0) chk("R8", "tach under brake", tach, 0);
      step(1);
    end
    brake = 1'b0;
    step(1);
    for (int i = 0; i < 10; i++) begin
      if (tach !== 1'b0) chk("R8", "tach after release", tach, 0);
      step(1);
    end
    chk("R8", "tach after release", tach, 0);
  endtask

  task automatic t_steady;
    for (int i = 0; i < 20; i++) begin
      if (tach !== 1'b0 || pos !== 3'b110) chk("R9", "steady pos", pos, 3'b110);
      step(1);
    end
    chk("R9", "steady tach", tach, 0);
    chk("R9", "steady pos", pos, 3'b110);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    step(3);
    t_reset;
    t_commutation;
    t_widths;
    t_retrigger;
    t_brake;
    t_steady;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary;
      $finish;
    end
  end
endmodule